// File: doc/BRIEF.md
# Indirect Calibration Register Port

This block lets a host reach a small internal register file, such as the calibration space of a delay-locked loop, through a narrow window of 32-bit host registers. The host does not address the internal registers directly. It first writes a command word that holds the direction and the internal address. For a write, it also loads a data word. It then raises a start bit. The port runs the internal access in a fixed busy window. The result of a read comes back in a separate host register.

Three internal locations have fixed roles. Location zero holds the write-protect lock. Only one 32-bit unlock key opens it, and any other value written there closes it again. One location holds a manual-calibration enable and a 5-bit code, and both drive output pins. Another location is read-only and returns a 5-bit calibration code taken from an input pin. Every other location is general storage. While the lock is closed, writes to every location except location zero are dropped without notice.

Top module: `calib_port`

## Requirements
- R1: After a synchronous reset the port is in the following state. The lock is closed (`wp_active_o` = 1). Manual mode is off and the manual code is 0. `busy_o` is 0. The command, data-in and data-out host registers all read 0. Every internal location reads 0.
- R2: The command register at host offset 0x830 keeps the internal address in bits 5:0 and the direction in bit 8, where 1 means read and 0 means write. All other written bits are discarded and read back as 0.
- R3: An internal access is launched only when bit 0 of the start register at host offset 0x82c goes from 0 to 1. Writing 1 again while that bit is already 1 launches nothing. A rising edge that arrives while `busy_o` is high is ignored.
- R4: After a launch, `busy_o` stays high for exactly BUSY_CYCLES clock cycles. The data-out register already holds the read result when `busy_o` falls, and it does not change afterwards.
- R5: Write data is taken from the data-in register at host offset 0x834. Read data appears in the data-out register at host offset 0x838. A general internal location returns the last value written to it while the lock was open. A location that was never written returns 0.
- R6: An internal write of 0xA5000000 to location 0x00 opens the lock, and `wp_active_o` goes to 0. An internal write of any other value to location 0x00 closes the lock. An internal read of location 0x00 returns the lock state in bit 0, where 1 means closed.
- R7: While the lock is closed, internal writes to any location other than 0x00 have no effect.
- R8: An internal read of location 0x26 returns `cal_code_i` zero-extended to 32 bits. Internal writes to location 0x26 have no effect.
- R9: Location 0x22 stores a manual-mode flag in bit 7 and a calibration code in bits 4:0. These drive `manual_en_o` and `manual_code_o`. Its other bits read as 0.
- R10: Host reads of unmapped offsets return 0. Only an internal read access changes the data-out register.
- R11: Every host read is answered with `bus_rvalid` high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 12 | Host byte offset |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| cal_code_i | input | 5 | Calibration code returned by location 0x26 |
| busy_o | output | 1 | Internal access in progress |
| wp_active_o | output | 1 | Write protection in force |
| manual_en_o | output | 1 | Manual calibration flag from location 0x22 |
| manual_code_o | output | 5 | Manual calibration code from location 0x22 |

## Verification
The bench builds the port with BUSY_CYCLES = 5 instead of the default 4. This means the busy-window length check and the check that data-out stays stable cannot pass just because a count happens to match the default. The 6-bit internal address and the 32-bit data width are left at their defaults. That lets the bench write and read back the top location 63, and it also exposes command-word masking at bit 6 and above. With the longer window, there is time to put a start-bit edge in the middle of an access and observe that the edge is ignored.

// File: rtl/calib_port_pkg.sv
package calib_port_pkg;

  localparam int IADDR_W = 6;
  localparam int DATA_W  = 32;

  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } dir_e;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_LOCK   = 2'd1,
    SRC_MANUAL = 2'd2,
    SRC_CALIB  = 2'd3
  } rd_src_e;

  typedef struct packed {
    dir_e               dir;
    logic [IADDR_W-1:0] addr;
    logic [DATA_W-1:0]  data;
  } iop_t;

endpackage

// File: rtl/calib_host_regs.sv
module calib_host_regs
  import calib_port_pkg::*;
#(
  parameter int              BUS_AW    = 12,
  parameter logic [11:0]     OFS_START = 12'h82c,
  parameter logic [11:0]     OFS_CMD   = 12'h830,
  parameter logic [11:0]     OFS_DIN   = 12'h834,
  parameter logic [11:0]     OFS_DOUT  = 12'h838,
  parameter int              DIR_BIT   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output iop_t              op,
  output logic              launch,
  input  logic              capture,
  input  logic [DATA_W-1:0] cap_data,
  output logic [DATA_W-1:0] dout_o
);

  logic               cmd_dir;
  logic [IADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0]  din_q;
  logic [DATA_W-1:0]  dout_q;
  logic               start_q;
  logic               launch_q;
  logic [DATA_W-1:0]  rdata_q;
  logic               rvalid_q;
  logic [DATA_W-1:0]  rd_mux;

  wire hit_start = (bus_addr == BUS_AW'(OFS_START));
  wire hit_cmd   = (bus_addr == BUS_AW'(OFS_CMD));
  wire hit_din   = (bus_addr == BUS_AW'(OFS_DIN));
  wire hit_dout  = (bus_addr == BUS_AW'(OFS_DOUT));

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_dir  <= 1'b0;
      cmd_addr <= '0;
      din_q    <= '0;
      start_q  <= 1'b0;
      launch_q <= 1'b0;
    end else begin
      launch_q <= bus_wr && hit_start && bus_wdata[0] && !start_q;
      if (bus_wr && hit_start) start_q <= bus_wdata[0];
      if (bus_wr && hit_cmd) begin
        cmd_dir  <= bus_wdata[DIR_BIT];
        cmd_addr <= bus_wdata[IADDR_W-1:0];
      end
      if (bus_wr && hit_din) din_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          dout_q <= '0;
    else if (capture) dout_q <= cap_data;
  end

  always_comb begin
    rd_mux = '0;
    if (hit_start) begin
      rd_mux[0] = start_q;
    end else if (hit_cmd) begin
      rd_mux[DIR_BIT]       = cmd_dir;
      rd_mux[IADDR_W-1:0]   = cmd_addr;
    end else if (hit_din) begin
      rd_mux = din_q;
    end else if (hit_dout) begin
      rd_mux = dout_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd;
      if (bus_rd) rdata_q <= rd_mux;
    end
  end

  assign op         = '{dir: dir_e'(cmd_dir), addr: cmd_addr, data: din_q};
  assign launch     = launch_q;
  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign dout_o     = dout_q;

endmodule

// File: rtl/calib_access_seq.sv
module calib_access_seq
  import calib_port_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic launch,
  input  iop_t op_in,
  output iop_t op_q,
  output logic busy,
  output logic exec,
  output logic capture_rd
);

  localparam int CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BUSY_CYCLES - 1);

  generate
    if (BUSY_CYCLES < 4) begin : g_bad_window
      $error("BUSY_CYCLES must be at least 4");
    end
  endgenerate

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  iop_t             held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      held_q <= '0;
    end else if (!busy_q) begin
      if (launch) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        held_q <= op_in;
      end
    end else if (cnt_q == LAST) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy       = busy_q;
  assign op_q       = held_q;
  assign exec       = busy_q && (cnt_q == '0);
  assign capture_rd = busy_q && (cnt_q == CNT_W'(1)) && (held_q.dir == DIR_READ);

endmodule

// File: rtl/calib_reg_file.sv
module calib_reg_file
  import calib_port_pkg::*;
#(
  parameter logic [DATA_W-1:0]  UNLOCK_KEY = 32'hA500_0000,
  parameter logic [IADDR_W-1:0] ADR_LOCK   = 6'h00,
  parameter logic [IADDR_W-1:0] ADR_MANUAL = 6'h22,
  parameter logic [IADDR_W-1:0] ADR_CALIB  = 6'h26,
  parameter int                 MAN_BIT    = 7,
  parameter int                 CODE_W     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exec,
  input  iop_t              op,
  input  logic [CODE_W-1:0] cal_code,
  output logic [DATA_W-1:0] rd_data,
  output logic              locked,
  output logic              manual_en,
  output logic [CODE_W-1:0] manual_code
);

  localparam int DEPTH = 1 << IADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] mem_q;
  logic [DEPTH-1:0]  vld;
  logic              vld_q;
  rd_src_e           src_q;
  logic [DATA_W-1:0] spec_q;
  logic              locked_q;
  logic              man_q;
  logic [CODE_W-1:0] code_q;
  rd_src_e           src_d;
  logic [DATA_W-1:0] spec_d;

  wire do_wr    = exec && (op.dir == DIR_WRITE);
  wire do_rd    = exec && (op.dir == DIR_READ);
  wire is_array = (src_d == SRC_ARRAY);
  wire arr_wr   = do_wr && is_array && !locked_q;

  always_comb begin
    spec_d = '0;
    if (op.addr == ADR_LOCK) begin
      src_d     = SRC_LOCK;
      spec_d[0] = locked_q;
    end else if (op.addr == ADR_MANUAL) begin
      src_d                = SRC_MANUAL;
      spec_d[MAN_BIT]      = man_q;
      spec_d[CODE_W-1:0]   = code_q;
    end else if (op.addr == ADR_CALIB) begin
      src_d              = SRC_CALIB;
      spec_d[CODE_W-1:0] = cal_code;
    end else begin
      src_d = SRC_ARRAY;
    end
  end

  // storage array without reset so it can map onto block RAM
  always_ff @(posedge clk) begin
    if (arr_wr) mem[op.addr] <= op.data;
    if (do_rd)  mem_q <= mem[op.addr];
  end

  // per-entry written flags give the all-zero reset view
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_vld
      always_ff @(posedge clk) begin
        if (rst)                                      vld[i] <= 1'b0;
        else if (arr_wr && op.addr == IADDR_W'(i))    vld[i] <= 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      src_q  <= SRC_ARRAY;
      spec_q <= '0;
    end else if (do_rd) begin
      vld_q  <= vld[op.addr];
      src_q  <= src_d;
      spec_q <= spec_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b1;
      man_q    <= 1'b0;
      code_q   <= '0;
    end else if (do_wr) begin
      if (src_d == SRC_LOCK) begin
        locked_q <= (op.data != UNLOCK_KEY);
      end else if (src_d == SRC_MANUAL && !locked_q) begin
        man_q  <= op.data[MAN_BIT];
        code_q <= op.data[CODE_W-1:0];
      end
    end
  end

  assign rd_data     = (src_q == SRC_ARRAY) ? (vld_q ? mem_q : '0) : spec_q;
  assign locked      = locked_q;
  assign manual_en   = man_q;
  assign manual_code = code_q;

endmodule

// File: rtl/calib_port.sv
module calib_port
  import calib_port_pkg::*;
#(
  parameter int BUS_AW      = 12,
  parameter int BUSY_CYCLES = 4,
  parameter int CODE_W      = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic [CODE_W-1:0] cal_code_i,
  output logic              busy_o,
  output logic              wp_active_o,
  output logic              manual_en_o,
  output logic [CODE_W-1:0] manual_code_o
);

  iop_t              host_op;
  iop_t              run_op;
  logic              launch;
  logic              exec;
  logic              capture_rd;
  logic [DATA_W-1:0] rf_rdata;
  logic [DATA_W-1:0] dout_w;

  calib_host_regs #(
    .BUS_AW(BUS_AW)
  ) u_host (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_rvalid(bus_rvalid),
    .op        (host_op),
    .launch    (launch),
    .capture   (capture_rd),
    .cap_data  (rf_rdata),
    .dout_o    (dout_w)
  );

  calib_access_seq #(
    .BUSY_CYCLES(BUSY_CYCLES)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .launch    (launch),
    .op_in     (host_op),
    .op_q      (run_op),
    .busy      (busy_o),
    .exec      (exec),
    .capture_rd(capture_rd)
  );

  calib_reg_file #(
    .CODE_W(CODE_W)
  ) u_rf (
    .clk        (clk),
    .rst        (rst),
    .exec       (exec),
    .op         (run_op),
    .cal_code   (cal_code_i),
    .rd_data    (rf_rdata),
    .locked     (wp_active_o),
    .manual_en  (manual_en_o),
    .manual_code(manual_code_o)
  );

endmodule

// File: rtl/calib_port_chk.sv
module calib_port_chk #(
  parameter int BUSY_CYCLES = 4,
  parameter int CODE_W      = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic              bus_rvalid,
  input logic              busy_o,
  input logic              wp_active_o,
  input logic              manual_en_o,
  input logic [CODE_W-1:0] manual_code_o,
  input logic [31:0]       dout
);

  int busy_len;

  always_ff @(posedge clk) begin
    if (rst)         busy_len <= 0;
    else if (busy_o) busy_len <= busy_len + 1;
    else             busy_len <= 0;
  end

  // R4: busy window has the configured length
  a_r4_busy_len: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (busy_len == BUSY_CYCLES));

  // R4: read result already in place when busy drops
  a_r4_dout_settled: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> $stable(dout));

  // R7: manual fields cannot move while the lock stays closed
  a_r7_locked_hold: assert property (@(posedge clk) disable iff (rst)
    (wp_active_o && $past(wp_active_o)) |-> $stable({manual_en_o, manual_code_o}));

  // R1: state right after a reset cycle
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wp_active_o && !busy_o && !manual_en_o));

  // R11: each host read is answered next cycle
  a_r11_rvalid: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

endmodule

bind calib_port calib_port_chk #(
  .BUSY_CYCLES(BUSY_CYCLES),
  .CODE_W     (CODE_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_rd       (bus_rd),
  .bus_rvalid   (bus_rvalid),
  .busy_o       (busy_o),
  .wp_active_o  (wp_active_o),
  .manual_en_o  (manual_en_o),
  .manual_code_o(manual_code_o),
  .dout         (dout_w)
);

// File: tb/calib_port_tb.sv
module calib_port_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BUSY       = 5;
  localparam logic [11:0] A_START = 12'h82c;
  localparam logic [11:0] A_CMD   = 12'h830;
  localparam logic [11:0] A_DIN   = 12'h834;
  localparam logic [11:0] A_DOUT  = 12'h838;
  localparam logic [31:0] KEY     = 32'hA500_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [4:0]  cal_code_i = '0;
  logic        busy_o;
  logic        wp_active_o;
  logic        manual_en_o;
  logic [4:0]  manual_code_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  calib_port #(.BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .cal_code_i(cal_code_i), .busy_o(busy_o),
    .wp_active_o(wp_active_o), .manual_en_o(manual_en_o),
    .manual_code_o(manual_code_o)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected rvalid", bus_rdata, 32'h0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(bus_rdata === e, t, bus_rdata, e);
      end
    end
  end

  task automatic host_write(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic host_read(input logic [11:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle(input string t);
    int cnt = 0;
    while (busy_o) begin cnt++; @(negedge clk); end
    check(cnt == BUSY, t, cnt, BUSY);
  endtask

  task automatic access(input bit rd, input logic [5:0] a, input logic [31:0] d);
    host_write(A_CMD, {23'b0, rd, 2'b0, a});
    if (!rd) host_write(A_DIN, d);
    host_write(A_START, 32'h1);
    host_write(A_START, 32'h0);
    wait_idle("R4 busy length");
  endtask

  task automatic iread(input logic [5:0] a, input logic [31:0] e, input string t);
    access(1'b1, a, 32'h0);
    host_read(A_DOUT, e, t);
  endtask

  task automatic quiet(input int n, input string t);
    for (int i = 0; i < n; i++) begin
      check(busy_o == 1'b0, t, busy_o, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(wp_active_o == 1'b1, "R1 wp after reset", wp_active_o, 1);
    check(manual_en_o == 1'b0 && manual_code_o == 5'h0, "R1 manual after reset",
          {manual_en_o, manual_code_o}, 0);
    check(busy_o == 1'b0, "R1 busy after reset", busy_o, 0);
    host_read(A_CMD,  32'h0, "R1 command reg reset");
    host_read(A_DIN,  32'h0, "R1 data-in reset");
    host_read(A_DOUT, 32'h0, "R1 data-out reset");

    // R2 command masking
    host_write(A_CMD, 32'hFFFF_FFFF);
    host_read(A_CMD, 32'h0000_013F, "R2 command mask all ones");
    host_write(A_CMD, 32'h0000_0145);
    host_read(A_CMD, 32'h0000_0105, "R2 address bit 6 dropped");

    // R7 writes dropped while locked
    access(1'b0, 6'h05, 32'h1234_5678);
    iread(6'h05, 32'h0, "R7 locked array write dropped");
    access(1'b0, 6'h22, 32'h0000_009F);
    check(manual_en_o == 1'b0 && manual_code_o == 5'h0, "R7 locked manual write dropped",
          {manual_en_o, manual_code_o}, 0);
    iread(6'h00, 32'h1, "R6 lock reads closed");

    // R6 unlock
    access(1'b0, 6'h00, KEY);
    check(wp_active_o == 1'b0, "R6 key opens lock", wp_active_o, 0);
    iread(6'h00, 32'h0, "R6 lock reads open");

    // R5 storage
    access(1'b0, 6'h05, 32'hDEAD_BEEF);
    access(1'b0, 6'h3F, 32'hCAFE_F00D);
    iread(6'h05, 32'hDEAD_BEEF, "R5 location 5");
    iread(6'h3F, 32'hCAFE_F00D, "R5 top location 63");
    iread(6'h06, 32'h0, "R5 unwritten location");
    host_read(A_DIN, 32'hCAFE_F00D, "R5 data-in holds last value");

    // R9 manual field
    access(1'b0, 6'h22, 32'hFFFF_FF93);
    check(manual_en_o == 1'b1 && manual_code_o == 5'h13, "R9 manual pins",
          {manual_en_o, manual_code_o}, {1'b1, 5'h13});
    iread(6'h22, 32'h0000_0093, "R9 manual readback");

    // R8 calibration code
    cal_code_i = 5'h16;
    iread(6'h26, 32'h0000_0016, "R8 calib code");
    access(1'b0, 6'h26, 32'hFFFF_FFFF);
    iread(6'h26, 32'h0000_0016, "R8 calib write ignored");

    // R10 write access leaves data-out, unmapped offset
    access(1'b0, 6'h07, 32'h5555_AAAA);
    host_read(A_DOUT, 32'h0000_0016, "R10 data-out kept over write access");
    host_read(12'h840, 32'h0, "R10 unmapped offset");

    // R3 second 1 without a 0 launches nothing
    host_write(A_CMD, 32'h0000_0105);
    host_write(A_START, 32'h1);
    host_write(A_START, 32'h1);
    wait_idle("R4 busy length held start");
    quiet(BUSY + 2, "R3 repeated one ignored");
    host_write(A_START, 32'h0);
    // R3 edge during busy ignored
    host_write(A_START, 32'h1);
    host_write(A_START, 32'h0);
    host_write(A_START, 32'h1);
    while (busy_o) @(negedge clk);
    quiet(BUSY + 2, "R3 edge during busy ignored");
    host_write(A_START, 32'h0);

    // R6 relock, R7 dropped again
    access(1'b0, 6'h00, 32'hA500_0001);
    check(wp_active_o == 1'b1, "R6 wrong value closes lock", wp_active_o, 1);
    access(1'b0, 6'h05, 32'h0000_0001);
    iread(6'h05, 32'hDEAD_BEEF, "R7 relocked write dropped");
    access(1'b0, 6'h22, 32'h0);
    check(manual_en_o == 1'b1, "R7 relocked manual kept", manual_en_o, 1);

    // R1 reset mid-run
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(wp_active_o == 1'b1 && manual_en_o == 1'b0, "R1 second reset",
          {wp_active_o, manual_en_o}, 2);
    iread(6'h05, 32'h0, "R1 array cleared by reset");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R11 all reads answered", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule